// File: doc/BRIEF.md
# Twiddle Exponent Sequencer for a Pipelined FFT Stage

This block drives the general complex multiplier that sits after a pair of radix-2 butterflies in a single-path delay-feedback FFT pipeline. For every sample that enters the multiplier it produces the twiddle exponent e of W_R^e, where R = 2^LOG_RES is the resolution of that multiplier (16, 64 or 256 in a 256-point pipeline built on the radix-2^2 scheme). It also splits that exponent into a quadrant select and an address within the quadrant, so that a quarter-wave coefficient table can be used. One result comes out per accepted sample, one clock after it, in step with the data stream.

The exponent comes from a mixed-radix index map, not from a linear count. A frame counter gives the time index i of the sample, 0 to R-1. Its low LOG_RES-2 bits form the inner digit n, which runs 0 to R/4-1. Its top two bits u name the quarter of the frame, and they map to a frequency weight w in 0..3. The exponent is n*w mod R. The parameter K_ORDER selects how u becomes w. In the reversed order used by decimation-in-frequency, w = {u[0], u[1]}. In the natural order, w = u. The coefficient table and the multiplier itself lie outside this block.

Top module: `tw_exp_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, tw_valid, tw_last, tw_exp, tw_quadrant and tw_rom_addr are all zero. The first accepted sample after reset has time index 0, even without in_start.
- R2: A cycle with in_valid=1 gives tw_valid=1 on the next cycle. A cycle with in_valid=0 gives tw_valid=0 on the next cycle, and tw_exp, tw_quadrant and tw_rom_addr keep their previous values.
- R3: The time index goes up by one for each accepted sample and wraps from R-1 to 0. Cycles with in_valid=0 leave it unchanged.
- R4: An accepted sample with in_start=1 takes time index 0, and the sample after it takes index 1.
- R5: in_start while in_valid=0 is ignored. The next accepted sample takes the index that was due before the strobe.
- R6: For time index i, tw_exp = (i mod R/4) * w mod R, where u = i div (R/4), w = {u[0],u[1]} when K_ORDER is reversed (0) and w = u when it is natural (1). As a result, tw_exp never exceeds 3*(R/4-1).
- R7: tw_quadrant equals tw_exp[LOG_RES-1:LOG_RES-2], and tw_rom_addr equals tw_exp[LOG_RES-3:0].
- R8: tw_last is 1 for exactly the result of the sample with time index R-1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data sample enters the multiplier this cycle |
| in_start | input | 1 | With in_valid, marks the first sample of a frame |
| tw_valid | output | 1 | The result for a sample accepted in the previous cycle is present |
| tw_last | output | 1 | The result belongs to the final sample of a frame |
| tw_exp | output | LOG_RES | Twiddle exponent, modulo R |
| tw_quadrant | output | 2 | Quadrant select, the top two exponent bits |
| tw_rom_addr | output | LOG_RES-2 | Address within the quadrant |

## Verification
Every output is registered once after the frame counter, so the result for a sample accepted at one rising edge is due from that edge until the next. The bench drives each sample at a falling edge and compares all five outputs at the following falling edge against a model that works out time index, weight and exponent from the requirements. On idle cycles the bench expects tw_valid and tw_last to drop in that same next cycle while the exponent fields hold. Four instances, at resolutions 256, 64 and 16 in reversed order and 256 in natural order, share the stimulus, so each wraps at its own frame length in the same run.

// File: rtl/tw_seq_pkg.sv
package tw_seq_pkg;

    // How the two quarter-of-frame bits map to the frequency weight.
    typedef enum logic [0:0] {
        K_ORDER_REVERSED = 1'b0,
        K_ORDER_NATURAL  = 1'b1
    } k_order_e;

    localparam int unsigned QUAD_BITS   = 2;
    localparam int unsigned WEIGHT_BITS = 2;

    // Bit swap of a two-bit quarter index.
    function automatic logic [WEIGHT_BITS-1:0] swap2(input logic [WEIGHT_BITS-1:0] u);
        return {u[0], u[1]};
    endfunction

endpackage

// File: rtl/tw_frame_counter.sv
module tw_frame_counter #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             restart,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [IDX_W-1:0] cnt_q;

    // Index of the sample presented this cycle.
    assign idx_o  = restart ? '0 : cnt_q;
    assign last_o = (idx_o == IDX_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= idx_o + IDX_ONE;
        end
    end

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && !restart && cnt_q == IDX_MAX) |=> (cnt_q == '0));

    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && restart) |=> (cnt_q == IDX_ONE));

endmodule

// File: rtl/tw_digit_split.sv
module tw_digit_split
    import tw_seq_pkg::*;
#(
    parameter int unsigned IDX_W   = 8,
    parameter k_order_e    K_ORDER = K_ORDER_REVERSED
) (
    input  logic [IDX_W-1:0]       idx,
    output logic [IDX_W-3:0]       n_digit,
    output logic [WEIGHT_BITS-1:0] weight
);
    logic [WEIGHT_BITS-1:0] quarter;

    assign n_digit = idx[IDX_W-3:0];
    assign quarter = idx[IDX_W-1:IDX_W-2];

    generate
        if (K_ORDER == K_ORDER_NATURAL) begin : g_natural
            assign weight = quarter;
        end else begin : g_reversed
            assign weight = swap2(quarter);
        end
    endgenerate

endmodule

// File: rtl/tw_exp_mult.sv
module tw_exp_mult
    import tw_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic [IDX_W-3:0]       n_digit,
    input  logic [WEIGHT_BITS-1:0] weight,
    output logic [IDX_W-1:0]       expo
);
    logic [IDX_W-1:0] partial [WEIGHT_BITS];
    logic [IDX_W-1:0] n_wide;

    assign n_wide = {2'b00, n_digit};

    // Shift-and-add product of the inner digit and the two-bit weight.
    generate
        for (genvar j = 0; j < WEIGHT_BITS; j++) begin : g_part
            assign partial[j] = weight[j] ? (n_wide << j) : '0;
        end
    endgenerate

    // The sum is kept to IDX_W bits, which is the modulo-R reduction.
    assign expo = partial[0] + partial[1];

endmodule

// File: rtl/tw_exp_sequencer.sv
module tw_exp_sequencer
    import tw_seq_pkg::*;
#(
    parameter int unsigned LOG_RES = 8,
    parameter k_order_e    K_ORDER = K_ORDER_REVERSED
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_start,
    output logic                 tw_valid,
    output logic                 tw_last,
    output logic [LOG_RES-1:0]   tw_exp,
    output logic [QUAD_BITS-1:0] tw_quadrant,
    output logic [LOG_RES-3:0]   tw_rom_addr
);
    localparam int unsigned RES     = 1 << LOG_RES;
    localparam int unsigned EXP_MAX = 3 * (RES / 4 - 1);

    typedef struct packed {
        logic               valid;
        logic               last;
        logic [LOG_RES-1:0] expo;
    } tw_word_t;

    logic [LOG_RES-1:0]     idx;
    logic                   idx_last;
    logic [LOG_RES-3:0]     n_digit;
    logic [WEIGHT_BITS-1:0] weight;
    logic [LOG_RES-1:0]     expo_c;
    tw_word_t               out_q;

    tw_frame_counter #(.IDX_W(LOG_RES)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .restart (in_start),
        .idx_o   (idx),
        .last_o  (idx_last)
    );

    tw_digit_split #(.IDX_W(LOG_RES), .K_ORDER(K_ORDER)) u_split (
        .idx     (idx),
        .n_digit (n_digit),
        .weight  (weight)
    );

    tw_exp_mult #(.IDX_W(LOG_RES)) u_mult (
        .n_digit (n_digit),
        .weight  (weight),
        .expo    (expo_c)
    );

    // One register stage aligns the exponent with the sample at the multiplier.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid;
            out_q.last  <= in_valid & idx_last;
            if (in_valid) begin
                out_q.expo <= expo_c;
            end
        end
    end

    assign tw_valid    = out_q.valid;
    assign tw_last     = out_q.last;
    assign tw_exp      = out_q.expo;
    assign tw_quadrant = out_q.expo[LOG_RES-1:LOG_RES-2];
    assign tw_rom_addr = out_q.expo[LOG_RES-3:0];

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!tw_valid && !tw_last && tw_exp == '0));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> tw_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!tw_valid && $stable(tw_exp)));

    p_exp_bound_r6: assert property (@(posedge clk) disable iff (rst)
        tw_valid |-> (int'(tw_exp) <= EXP_MAX));

    p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
        tw_last |-> tw_valid);

endmodule

// File: tb/tw_exp_sequencer_tb_top.sv
`timescale 1ns/1ps
module tw_exp_sequencer_tb_top;
    import tw_seq_pkg::*;

    localparam int NCFG = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    logic       v8, l8, v6, l6, v4, l4, vn, ln;
    logic [7:0] e8, en;
    logic [5:0] e6, a8, an;
    logic [3:0] e4, a6;
    logic [1:0] q8, q6, q4, qn, a4;

    tw_exp_sequencer #(.LOG_RES(8), .K_ORDER(K_ORDER_REVERSED)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .tw_valid(v8), .tw_last(l8), .tw_exp(e8), .tw_quadrant(q8), .tw_rom_addr(a8));
    tw_exp_sequencer #(.LOG_RES(6), .K_ORDER(K_ORDER_REVERSED)) dut64_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .tw_valid(v6), .tw_last(l6), .tw_exp(e6), .tw_quadrant(q6), .tw_rom_addr(a6));
    tw_exp_sequencer #(.LOG_RES(4), .K_ORDER(K_ORDER_REVERSED)) dut16_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .tw_valid(v4), .tw_last(l4), .tw_exp(e4), .tw_quadrant(q4), .tw_rom_addr(a4));
    tw_exp_sequencer #(.LOG_RES(8), .K_ORDER(K_ORDER_NATURAL)) dutnat_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .tw_valid(vn), .tw_last(ln), .tw_exp(en), .tw_quadrant(qn), .tw_rom_addr(an));

    // Reference model state, one slot per configuration.
    int m_idx  [NCFG];
    int m_exp  [NCFG];
    bit m_v    [NCFG];
    bit m_last [NCFG];

    function automatic int cfg_l(input int c);
        case (c)
            0: return 8;
            1: return 6;
            2: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic bit cfg_nat(input int c);
        return (c == 3);
    endfunction

    // R6: exponent from the index map.
    function automatic int ref_exp(input int c, input int i);
        int r, q, n, u, w;
        r = 1 << cfg_l(c);
        q = r / 4;
        n = i % q;
        u = i / q;
        w = cfg_nat(c) ? u : (((u & 1) << 1) | (u >> 1));
        return (n * w) % r;
    endfunction

    task automatic read_dut(input int c, output int v, output int l, output int e,
                            output int q, output int a);
        case (c)
            0: begin v = int'(v8); l = int'(l8); e = int'(e8); q = int'(q8); a = int'(a8); end
            1: begin v = int'(v6); l = int'(l6); e = int'(e6); q = int'(q6); a = int'(a6); end
            2: begin v = int'(v4); l = int'(l4); e = int'(e4); q = int'(q4); a = int'(a4); end
            default: begin v = int'(vn); l = int'(ln); e = int'(en); q = int'(qn); a = int'(an); end
        endcase
    endtask

    task automatic chk(input string tag, input string what, input int c,
                       input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s cfg=%0d actual=%0d expected=%0d", tag, what, c, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCFG; c++) begin
            int v, l, e, q, a, lw;
            lw = cfg_l(c);
            read_dut(c, v, l, e, q, a);
            chk(tag, "R2 valid", c, v, int'(m_v[c]));
            chk(tag, "R6 exponent", c, e, m_exp[c]);
            chk(tag, "R7 quadrant", c, q, m_exp[c] >> (lw - 2));
            chk(tag, "R7 rom address", c, a, m_exp[c] % (1 << (lw - 2)));
            chk(tag, "R8 last", c, l, int'(m_last[c]));
        end
    endtask

    // One cycle: drive at a falling edge, compare at the next falling edge.
    task automatic step(input bit v, input bit s, input string tag);
        in_valid = v;
        in_start = s;
        for (int c = 0; c < NCFG; c++) begin
            int r, use_i;
            r = 1 << cfg_l(c);
            if (v) begin
                use_i     = s ? 0 : m_idx[c];
                m_exp[c]  = ref_exp(c, use_i);
                m_last[c] = (use_i == r - 1);
                m_idx[c]  = (use_i + 1) % r;
                m_v[c]    = 1'b1;
            end else begin
                m_v[c]    = 1'b0;
                m_last[c] = 1'b0;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        in_valid = 1'b0;
        in_start = 1'b0;
        for (int c = 0; c < NCFG; c++) begin
            m_idx[c] = 0; m_exp[c] = 0; m_v[c] = 0; m_last[c] = 0;
        end
        repeat (3) begin
            @(negedge clk);
            check_all("R1");
        end
        rst = 1'b0;
        step(1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
    endtask

    task automatic t_full_frame;
        step(1'b1, 1'b1, "R4");
        for (int i = 1; i < 256; i++) step(1'b1, 1'b0, "R6");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R3");
    endtask

    task automatic t_gaps;
        for (int i = 0; i < 40; i++) step(i[0], 1'b0, "R2");
        repeat (30) step(1'b0, 1'b0, "R2");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R3");
    endtask

    task automatic t_start_ignored;
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, "R5");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R5");
    endtask

    task automatic t_restart_mid;
        for (int i = 0; i < 37; i++) step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R4");
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, "R8");
        step(1'b0, 1'b0, "R2");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_frame();
        t_gaps();
        t_start_ignored();
        t_restart_mid();
        t_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule